// File: doc/BRIEF.md
# Programmable Chip Select Area Decoder

This block sits between an internal bus master and the external memory controller. It takes a 32-bit logical address and finds which of eight chip select areas owns it. Each area has its own base, size, enable, write protection, bus width, byte order and burst limit. For each request it returns a one-hot chip select together with the attributes of the winning area, or an error flag. Bus timing is handled elsewhere.

Software programs each area through a write-only port. Every area has two words. The geometry word holds the base tag and the size code. The attribute word holds the enable, protection and format bits.

A small response state machine registers the outcome of every request. It has three states:
- `RSP_IDLE`: no response this cycle.
- `RSP_HIT`: a chip select is driven with its attributes.
- `RSP_FAULT`: the error flag is driven.

From any state, the next state is:
- `RSP_HIT` if a request is present, an enabled area matches, and the access is not a write to a protected area.
- `RSP_FAULT` for any other request.
- `RSP_IDLE` when no request is present.

Top module: `cs_area_decoder`

## Requirements
- R1: After reset, area 0 is enabled with base tag 0 and size code 0 (64 KB at 0x0000_0000), 8-bit width, big endian, burst length 1 and no write protection. Areas 1 to 7 are disabled, and no response is driven.
- R2: A request sampled at a clock edge produces a response (rsp_valid high) in the following cycle, for exactly one cycle. A cycle with no request is followed by rsp_valid, rsp_cs and rsp_err all low.
- R3: Let k be the size code (geometry word bits [3:0], 0 to 15). Area i then covers 64 KB << k bytes, so code 15 gives 2 GB. Area i matches when req_addr[31:16] equals the base tag in every bit except the lowest k bits; base bits below the size are ignored.
- R4: When several enabled areas match, the lowest-numbered one is selected.
- R5: A disabled area is never selected. A request that matches only disabled areas gets an error.
- R6: A request that no enabled area matches raises rsp_err with rsp_cs, rsp_wide, rsp_little_end and rsp_burst_len all zero.
- R7: A write to an area whose protect bit is set raises rsp_err with no chip select. A read of the same area is served normally.
- R8: On a hit, rsp_wide is attribute bit 2 (1 = 16-bit), rsp_little_end is attribute bit 3, and rsp_burst_len is 1 << attribute bits [5:4] (1, 2, 4 or 8).
- R9: Area 0 always reports big endian (rsp_little_end low), whatever value is written to its endian bit.
- R10: A configuration write with cfg_sel=0 loads the geometry word (base tag from bits [31:16], size code from bits [3:0]). With cfg_sel=1 it loads the attribute word (bit 0 enable, bit 1 write protect). Either write affects requests from the next cycle on.
- R11: Whenever rsp_valid is high, exactly one of two things holds: rsp_err is set, or exactly one chip select bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Area being configured |
| cfg_sel | input | 1 | 0 = geometry word, 1 = attribute word |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Logical address |
| rsp_valid | output | 1 | Response present |
| rsp_cs | output | 8 | One-hot chip select |
| rsp_err | output | 1 | Access error |
| rsp_wide | output | 1 | Selected area is 16-bit |
| rsp_little_end | output | 1 | Selected area is little endian |
| rsp_burst_len | output | 4 | Maximum burst length of selected area |

## Verification
The bench targets the following corner cases.
- **Overlapping areas.** A design with a reversed priority scan would select the higher-numbered area.
- **Size boundaries, including 2 GB.** An off-by-one mask would either take in the first 64 KB block past the end of an area or drop the top block of an area.
- **Disabled areas overlapping enabled ones.** A design that skips the enable check would pick the disabled area.
- **Protected writes.** A design that ignores direction would hit on the write or fault on the read.
- **Area 0 endian.** Writing little endian to area 0 catches a design that does not force its endian bit.

Random configuration writes mixed with random addresses then cover these rules together.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    typedef struct packed {
        logic       en;
        logic       wp;
        logic       wide;
        logic       le;
        logic [1:0] burst;
    } area_attr_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_FAULT
    } rsp_state_t;

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
    import cs_dec_pkg::*;
#(
    parameter int unsigned N_AREA = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SZ_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [$clog2(N_AREA)-1:0]         cfg_idx,
    input  logic                              cfg_sel,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [N_AREA-1:0][TAG_W-1:0]      base_o,
    output logic [N_AREA-1:0][SZ_W-1:0]       szc_o,
    output area_attr_t [N_AREA-1:0]           attr_o
);

    localparam int unsigned ATTR_W = $bits(area_attr_t);

    area_attr_t wr_attr;
    always_comb begin
        wr_attr.en    = cfg_wdata[0];
        wr_attr.wp    = cfg_wdata[1];
        wr_attr.wide  = cfg_wdata[2];
        wr_attr.le    = cfg_wdata[3];
        wr_attr.burst = cfg_wdata[5:4];
    end

    logic unused_bits;
    assign unused_bits = ^cfg_wdata[DATA_W-TAG_W-1:ATTR_W];

    for (genvar g = 0; g < N_AREA; g++) begin : g_area
        logic hit_idx;
        assign hit_idx = cfg_we && (cfg_idx == g[$clog2(N_AREA)-1:0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                szc_o[g]  <= '0;
            end else if (hit_idx && !cfg_sel) begin
                base_o[g] <= cfg_wdata[DATA_W-1 -: TAG_W];
                szc_o[g]  <= cfg_wdata[SZ_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_o[g]    <= '0;
                attr_o[g].en <= (g == 0);
            end else if (hit_idx && cfg_sel) begin
                attr_o[g] <= wr_attr;
                if (g == 0) begin
                    attr_o[g].le <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cs_area_match.sv
module cs_area_match #(
    parameter int unsigned TAG_W = 16,
    parameter int unsigned SZ_W  = 4
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] base_i,
    input  logic [SZ_W-1:0]  szc_i,
    input  logic             en_i,
    output logic             hit_o
);

    localparam int unsigned MAX_SHIFT = TAG_W - 1;

    logic [SZ_W-1:0]  shift;
    logic [TAG_W-1:0] mask;

    always_comb begin
        shift = (32'(szc_i) > MAX_SHIFT) ? SZ_W'(MAX_SHIFT) : szc_i;
        mask  = {TAG_W{1'b1}} << shift;
        hit_o = en_i && (((tag_i ^ base_i) & mask) == '0);
    end

endmodule

// File: rtl/cs_resp_fsm.sv
module cs_resp_fsm
    import cs_dec_pkg::*;
#(
    parameter int unsigned N_AREA = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [N_AREA-1:0]       hit_i,
    input  area_attr_t [N_AREA-1:0] attr_i,
    output logic                    rsp_valid,
    output logic [N_AREA-1:0]       rsp_cs,
    output logic                    rsp_err,
    output logic                    rsp_wide,
    output logic                    rsp_little_end,
    output logic [3:0]              rsp_burst_len
);

    rsp_state_t        state_q, state_d;
    logic [N_AREA-1:0] sel_cs;
    area_attr_t        sel_attr;
    logic              any_hit;
    logic [N_AREA-1:0] cs_q;
    area_attr_t        attr_q;

    // lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        sel_cs   = '0;
        sel_attr = '0;
        any_hit  = 1'b0;
        for (int i = N_AREA - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                sel_cs    = '0;
                sel_cs[i] = 1'b1;
                sel_attr  = attr_i[i];
                any_hit   = 1'b1;
            end
        end
    end

    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (any_hit && !(req_write && sel_attr.wp)) begin
            state_d = RSP_HIT;
        end else begin
            state_d = RSP_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            cs_q    <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSP_HIT) begin
                cs_q   <= sel_cs;
                attr_q <= sel_attr;
            end else begin
                cs_q   <= '0;
                attr_q <= '0;
            end
        end
    end

    always_comb begin
        rsp_valid      = 1'b0;
        rsp_cs         = '0;
        rsp_err        = 1'b0;
        rsp_wide       = 1'b0;
        rsp_little_end = 1'b0;
        rsp_burst_len  = '0;
        unique case (state_q)
            RSP_IDLE: begin
            end
            RSP_HIT: begin
                rsp_valid      = 1'b1;
                rsp_cs         = cs_q;
                rsp_wide       = attr_q.wide;
                rsp_little_end = attr_q.le;
                rsp_burst_len  = 4'd1 << attr_q.burst;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    logic unused_attr;
    assign unused_attr = attr_q.en ^ attr_q.wp;

endmodule

// File: rtl/cs_area_decoder.sv
module cs_area_decoder
    import cs_dec_pkg::*;
#(
    parameter int unsigned N_AREA = 8,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned GRAN_W = 16,
    parameter int unsigned SZ_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(N_AREA)-1:0] cfg_idx,
    input  logic                      cfg_sel,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      rsp_valid,
    output logic [N_AREA-1:0]         rsp_cs,
    output logic                      rsp_err,
    output logic                      rsp_wide,
    output logic                      rsp_little_end,
    output logic [3:0]                rsp_burst_len
);

    localparam int unsigned TAG_W = ADDR_W - GRAN_W;

    logic [N_AREA-1:0][TAG_W-1:0] base;
    logic [N_AREA-1:0][SZ_W-1:0]  szc;
    area_attr_t [N_AREA-1:0]      attr;
    logic [N_AREA-1:0]            hit;

    cs_cfg_bank #(
        .N_AREA (N_AREA),
        .DATA_W (ADDR_W),
        .TAG_W  (TAG_W),
        .SZ_W   (SZ_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base),
        .szc_o     (szc),
        .attr_o    (attr)
    );

    for (genvar g = 0; g < N_AREA; g++) begin : g_match
        cs_area_match #(
            .TAG_W (TAG_W),
            .SZ_W  (SZ_W)
        ) u_match (
            .tag_i  (req_addr[ADDR_W-1:GRAN_W]),
            .base_i (base[g]),
            .szc_i  (szc[g]),
            .en_i   (attr[g].en),
            .hit_o  (hit[g])
        );
    end

    cs_resp_fsm #(
        .N_AREA (N_AREA)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .hit_i          (hit),
        .attr_i         (attr),
        .rsp_valid      (rsp_valid),
        .rsp_cs         (rsp_cs),
        .rsp_err        (rsp_err),
        .rsp_wide       (rsp_wide),
        .rsp_little_end (rsp_little_end),
        .rsp_burst_len  (rsp_burst_len)
    );

    logic unused_low;
    assign unused_low = ^req_addr[GRAN_W-1:0];

endmodule

// File: rtl/cs_area_decoder_chk.sv
module cs_area_decoder_chk #(
    parameter int unsigned N_AREA = 8,
    parameter int unsigned ADDR_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [$clog2(N_AREA)-1:0] cfg_idx,
    input logic                      cfg_sel,
    input logic [ADDR_W-1:0]         cfg_wdata,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic                      rsp_valid,
    input logic [N_AREA-1:0]         rsp_cs,
    input logic                      rsp_err,
    input logic                      rsp_wide,
    input logic                      rsp_little_end,
    input logic [3:0]                rsp_burst_len
);

    assert_req_to_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_cs == '0 && !rsp_err));

    assert_cs_or_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err != ($countones(rsp_cs) == 1)));

    assert_err_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_cs == '0 && !rsp_wide && !rsp_little_end && rsp_burst_len == 4'd0));

    assert_area0_big_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cs[0] |-> !rsp_little_end);

    assert_burst_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ($countones(rsp_burst_len) == 1));

endmodule

bind cs_area_decoder cs_area_decoder_chk #(.N_AREA(N_AREA), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cs_area_decoder_tb.sv
module cs_area_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_cs;
    logic        rsp_err;
    logic        rsp_wide;
    logic        rsp_little_end;
    logic [3:0]  rsp_burst_len;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [15:0] m_base [8];
    logic [3:0]  m_sz   [8];
    logic        m_en   [8];
    logic        m_wp   [8];
    logic        m_wide [8];
    logic        m_le   [8];
    logic [1:0]  m_bur  [8];

    always #2.5 clk = ~clk;

    cs_area_decoder u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_idx        (cfg_idx),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .rsp_valid      (rsp_valid),
        .rsp_cs         (rsp_cs),
        .rsp_err        (rsp_err),
        .rsp_wide       (rsp_wide),
        .rsp_little_end (rsp_little_end),
        .rsp_burst_len  (rsp_burst_len)
    );

    function automatic logic [15:0] got_vec();
        return {rsp_valid, rsp_err, rsp_cs, rsp_wide, rsp_little_end, rsp_burst_len};
    endfunction

    function automatic logic [15:0] exp_vec(input logic [31:0] a, input logic w);
        int sel = -1;
        for (int i = 7; i >= 0; i--) begin
            logic [15:0] mask = 16'hFFFF << m_sz[i];
            if (m_en[i] && (((a[31:16] ^ m_base[i]) & mask) == 16'h0)) sel = i;
        end
        if (sel < 0 || (w && m_wp[sel])) return {2'b11, 8'h00, 6'h00};
        return {2'b10, 8'(8'd1 << sel), m_wide[sel], m_le[sel], 4'(4'd1 << m_bur[sel])};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_sz[i] = '0; m_en[i] = (i == 0);
            m_wp[i] = 0; m_wide[i] = 0; m_le[i] = 0; m_bur[i] = '0;
        end
    endtask

    task automatic cfg_write(input int idx, input logic sel, input logic [31:0] wd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = wd;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!sel) begin
            m_base[idx] = wd[31:16]; m_sz[idx] = wd[3:0];
        end else begin
            m_en[idx] = wd[0]; m_wp[idx] = wd[1]; m_wide[idx] = wd[2];
            m_le[idx] = (idx == 0) ? 1'b0 : wd[3]; m_bur[idx] = wd[5:4];
        end
    endtask

    task automatic do_req(input string tag, input logic [31:0] a, input logic w);
        logic [15:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        e = exp_vec(a, w);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, got_vec(), e);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        check(tag, got_vec(), 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle_check("R1 reset idle");
        do_req("R1 area0 boot read", 32'h0000_1234, 1'b0);
        do_req("R1 R6 above area0", 32'h0001_0000, 1'b0);
        idle_check("R2 no request");

        // R3 R8 R10: area 3, 1 MB at 0x4000_0000
        cfg_write(3, 1'b0, 32'h4000_0004);
        cfg_write(3, 1'b1, 32'h0000_003D);
        do_req("R3 R8 area3 inside", 32'h400A_BCDE, 1'b0);
        do_req("R3 area3 last byte", 32'h400F_FFFF, 1'b1);
        do_req("R3 area3 past end", 32'h4010_0000, 1'b0);
        cfg_write(3, 1'b0, 32'h4007_0004);
        do_req("R3 base low bits ignored", 32'h4000_0000, 1'b0);

        // R4 overlap
        cfg_write(1, 1'b0, 32'h4000_0000);
        cfg_write(1, 1'b1, 32'h0000_0011);
        do_req("R4 lower index wins", 32'h4000_0010, 1'b0);
        do_req("R4 outside small area", 32'h4001_0000, 1'b0);

        // R5 disabled
        cfg_write(1, 1'b1, 32'h0000_0010);
        do_req("R5 disabled area skipped", 32'h4000_0010, 1'b0);
        cfg_write(3, 1'b1, 32'h0000_003C);
        do_req("R5 only disabled match", 32'h4000_0010, 1'b0);

        // R7 protect on 2 GB area
        cfg_write(2, 1'b0, 32'h8000_000F);
        cfg_write(2, 1'b1, 32'h0000_0003);
        do_req("R7 protected write", 32'hFFFF_FFFC, 1'b1);
        do_req("R7 R3 protected read 2GB", 32'hFFFF_FFFC, 1'b0);
        do_req("R3 2GB lower edge", 32'h7FFF_FFFF, 1'b0);

        // R9 area 0 endian forced
        cfg_write(0, 1'b1, 32'h0000_002D);
        do_req("R9 area0 stays big", 32'h0000_0000, 1'b0);
        idle_check("R2 idle after request");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int k = int'($urandom_range(0, 9));
            if (k < 3) begin
                logic [31:0] wd = $urandom();
                if ($urandom_range(0, 1) == 0) wd[3:0] = 4'($urandom_range(0, 5));
                cfg_write(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), wd);
            end else if (k == 3) begin
                idle_check("R2 random idle");
            end else begin
                logic [31:0] a = $urandom();
                if ($urandom_range(0, 1) == 0) begin
                    int j = int'($urandom_range(0, 7));
                    a[31:16] = m_base[j] ^ 16'($urandom_range(0, 3));
                end
                do_req("R3 R4 R5 R6 R7 R8 R11 random", a, 1'($urandom_range(0, 1)));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule